// File: doc/BRIEF.md
# DS1 Alarm Indication Signal Monitor

This block inspects a received DS1 bit stream one bit per valid strobe and decides whether the far end is sending the all-ones alarm pattern. An external frame aligner supplies a strobe that marks framing-bit positions. The host picks one of two detection modes. In unframed mode every bit counts. In framed mode the framing-bit slots are skipped, so only payload bits must be ones. The block keeps a live alarm flag and a sticky flag that records any change of that alarm.

Observation runs in fixed windows of two frames (386 bit slots). At the end of each window the alarm is declared when the window held fewer than three counted zeros, and withdrawn otherwise. A small register port lets the host select the mode, set the interrupt enables, choose how the change flag is cleared, and read the status. The interrupt is a level that needs the change flag, a per-source enable and a block enable all at once.

Top module: `ds1_ais_monitor`

## Requirements
- R1: Mode codes 00 and 11 disable detection. While disabled, the alarm flag reads 0 from the cycle after the mode takes effect, and no line bits are counted.
- R2: Mode 01 (unframed) counts every zero in a window of 386 valid bit slots. After the window's last slot the alarm flag is 1 if the window held fewer than 3 zeros, and 0 otherwise.
- R3: Mode 10 (framed) applies the R2 rule, except that zeros on slots marked by the framing strobe are not counted.
- R4: The alarm flag changes only at the end of a window or when detection is disabled. Partway through a window the flag keeps its previous value.
- R5: Status bit 1 (change flag) is set whenever the alarm flag changes value, and it stays set until cleared.
- R6: When config bit 4 (clear-on-read) is 1, a read strobe to the status address (1) clears the change flag. When that bit is 0, reads leave the flag set.
- R7: Writing status address 1 with bit 1 high clears the change flag. Writing it with bit 1 low has no effect.
- R8: If the alarm changes in the same cycle as a clearing read, the change flag ends up set.
- R9: irq is high exactly when the change flag, config bit 2 (source enable) and config bit 3 (block enable) are all 1. Clearing any one of them drops irq.
- R10: After reset, config reads 0, status reads 0 and irq is 0.
- R11: Config at address 0 holds mode in bits [1:0], source enable in bit 2, block enable in bit 3 and clear-on-read in bit 4, and it reads back as written. Status bit 0 shows the alarm flag. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_in | input | 1 | Received bit value |
| fbit_strobe | input | 1 | Current bit occupies a framing slot |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (drives clear-on-read) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 5 | Write data |
| host_rdata | output | 5 | Read data for host_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clearing status read that lands on exactly the clock edge where a window closes and the alarm flips. The bench reaches it by feeding 385 bits of a window that will clear the alarm. It then drives the final bit and the status read strobe in the same cycle and checks that the change flag survives. Window alignment is kept deterministic by feeding whole windows between configuration writes and by passing through a disabled mode, which restarts the window count.

// File: rtl/ais_pkg.sv
package ais_pkg;

    localparam int REG_W       = 5;
    localparam int ADDR_W      = 2;
    localparam int STS_CHG_BIT = 1;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STS = 2'd1;

    typedef enum logic [1:0] {
        DET_OFF      = 2'b00,
        DET_UNFRAMED = 2'b01,
        DET_FRAMED   = 2'b10,
        DET_OFF_ALT  = 2'b11
    } det_mode_e;

    typedef struct packed {
        logic      cor;
        logic      blk_en;
        logic      src_en;
        det_mode_e mode;
    } cfg_t;

    typedef struct packed {
        logic chg;
        logic ais;
    } sts_t;

    function automatic logic mode_active(det_mode_e m);
        return (m == DET_UNFRAMED) || (m == DET_FRAMED);
    endfunction

    function automatic logic mask_fbit(det_mode_e m);
        return m == DET_FRAMED;
    endfunction

endpackage

// File: rtl/ais_window_det.sv
module ais_window_det
    import ais_pkg::*;
#(
    parameter int FRAME_BITS     = 193,
    parameter int FRAMES_PER_WIN = 2,
    parameter int ZERO_LIMIT     = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  det_mode_e mode,
    input  logic      bit_vld,
    input  logic      bit_in,
    input  logic      fbit,
    output logic      ais_q,
    output logic      ais_toggle,
    output logic      win_done
);

    localparam int WIN_BITS = FRAME_BITS * FRAMES_PER_WIN;
    localparam int BCNT_W   = $clog2(WIN_BITS);
    localparam int ZCNT_W   = $clog2(ZERO_LIMIT + 1);

    logic [BCNT_W-1:0] bit_cnt;
    logic [ZCNT_W-1:0] zero_cnt;
    logic [ZCNT_W:0]   zsum;
    logic              active;
    logic              count_zero;
    logic              verdict;
    logic              ais_next;

    always_comb begin
        active     = mode_active(mode);
        count_zero = active && bit_vld && !bit_in && !(mask_fbit(mode) && fbit);
        win_done   = active && bit_vld && (bit_cnt == BCNT_W'(WIN_BITS - 1));
        zsum       = {1'b0, zero_cnt} + (ZCNT_W + 1)'(count_zero);
        verdict    = zsum < (ZCNT_W + 1)'(ZERO_LIMIT);
        if (!active)
            ais_next = 1'b0;
        else if (win_done)
            ais_next = verdict;
        else
            ais_next = ais_q;
        ais_toggle = ais_next != ais_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            zero_cnt <= '0;
            ais_q    <= 1'b0;
        end else begin
            ais_q <= ais_next;
            if (!active || win_done) begin
                bit_cnt  <= '0;
                zero_cnt <= '0;
            end else if (bit_vld) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (count_zero && (zero_cnt != ZCNT_W'(ZERO_LIMIT)))
                    zero_cnt <= zero_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ais_host_regs.sv
module ais_host_regs
    import ais_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              ais_state,
    input  logic              ais_toggle,
    output cfg_t              cfg_q,
    output logic              chg_q,
    output logic [REG_W-1:0]  host_rdata
);

    logic wr_cfg;
    logic wr_sts;
    logic rd_sts;
    logic clr_req;
    sts_t sts_view;

    always_comb begin
        wr_cfg   = host_wr && (host_addr == ADDR_CFG);
        wr_sts   = host_wr && (host_addr == ADDR_STS);
        rd_sts   = host_rd && (host_addr == ADDR_STS);
        clr_req  = (rd_sts && cfg_q.cor) || (wr_sts && host_wdata[STS_CHG_BIT]);
        sts_view = '{chg: chg_q, ais: ais_state};
        case (host_addr)
            ADDR_CFG: host_rdata = cfg_q;
            ADDR_STS: host_rdata = REG_W'(sts_view);
            default:  host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            chg_q <= 1'b0;
        end else begin
            if (wr_cfg)
                cfg_q <= cfg_t'(host_wdata);
            if (ais_toggle)
                chg_q <= 1'b1;
            else if (clr_req)
                chg_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ais_irq_gate.sv
module ais_irq_gate
    import ais_pkg::*;
(
    input  cfg_t cfg,
    input  logic chg,
    output logic irq
);

    always_comb irq = chg && cfg.src_en && cfg.blk_en;

endmodule

// File: rtl/ds1_ais_monitor.sv
module ds1_ais_monitor
    import ais_pkg::*;
#(
    parameter int FRAME_BITS     = 193,
    parameter int FRAMES_PER_WIN = 2,
    parameter int ZERO_LIMIT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              fbit_strobe,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              irq
);

    cfg_t cfg_q;
    logic ais_state;
    logic ais_toggle;
    logic win_done;
    logic chg_flag;

    ais_window_det #(
        .FRAME_BITS    (FRAME_BITS),
        .FRAMES_PER_WIN(FRAMES_PER_WIN),
        .ZERO_LIMIT    (ZERO_LIMIT)
    ) u_det (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_q.mode),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .fbit      (fbit_strobe),
        .ais_q     (ais_state),
        .ais_toggle(ais_toggle),
        .win_done  (win_done)
    );

    ais_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .ais_state (ais_state),
        .ais_toggle(ais_toggle),
        .cfg_q     (cfg_q),
        .chg_q     (chg_flag),
        .host_rdata(host_rdata)
    );

    ais_irq_gate u_irq (
        .cfg(cfg_q),
        .chg(chg_flag),
        .irq(irq)
    );

endmodule

// File: rtl/ais_monitor_checker.sv
module ais_monitor_checker
    import ais_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input cfg_t              cfg,
    input logic              ais_state,
    input logic              ais_toggle,
    input logic              win_done,
    input logic              chg_flag,
    input logic              irq,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              wclr_bit
);

    logic rd_clear;
    logic wr_clear;

    always_comb begin
        rd_clear = host_rd && (host_addr == ADDR_STS) && cfg.cor;
        wr_clear = host_wr && (host_addr == ADDR_STS) && wclr_bit;
    end

    p_off_forces_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_active(cfg.mode) |=> !ais_state);

    p_update_at_window_end_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ais_state) |-> $past(win_done || !mode_active(cfg.mode)));

    p_change_flagged_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ais_state) |-> chg_flag);

    p_chg_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (chg_flag && !rd_clear && !wr_clear) |=> chg_flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ais_toggle |=> chg_flag);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        !(cfg.src_en && cfg.blk_en && chg_flag) |-> !irq);

    p_irq_raised_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.src_en && cfg.blk_en && chg_flag) |-> irq);

endmodule

bind ds1_ais_monitor ais_monitor_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg_q),
    .ais_state (ais_state),
    .ais_toggle(ais_toggle),
    .win_done  (win_done),
    .chg_flag  (chg_flag),
    .irq       (irq),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .wclr_bit  (host_wdata[ais_pkg::STS_CHG_BIT])
);

// File: tb/ds1_ais_monitor_tb.sv
module ds1_ais_monitor_tb;

    localparam int WIN = 386;
    localparam int F2  = 193;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b1;
    logic       fbit_strobe = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [4:0] host_wdata = 5'd0;
    logic [4:0] host_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ds1_ais_monitor u_dut (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .fbit_strobe(fbit_strobe),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

    // vector: [6:5] mode, [4:3] payload zeros, [2:1] framing-slot zeros, [0] expected alarm
    localparam logic [6:0] VECS [0:11] = '{
        {2'b01, 2'd0, 2'd0, 1'b1},
        {2'b01, 2'd2, 2'd0, 1'b1},
        {2'b01, 2'd3, 2'd0, 1'b0},
        {2'b01, 2'd0, 2'd2, 1'b1},
        {2'b01, 2'd1, 2'd2, 1'b0},
        {2'b10, 2'd1, 2'd2, 1'b1},
        {2'b10, 2'd2, 2'd2, 1'b1},
        {2'b10, 2'd3, 2'd0, 1'b0},
        {2'b10, 2'd0, 2'd0, 1'b1},
        {2'b00, 2'd0, 2'd0, 1'b0},
        {2'b11, 2'd0, 2'd0, 1'b0},
        {2'b01, 2'd0, 2'd0, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic line_bit(input int p, input int pz, input int fz);
        if (p == 0)   return !(fz > 0);
        if (p == F2)  return !(fz > 1);
        return !(p >= 1 && p <= pz);
    endfunction

    task automatic feed(input int first, input int count, input int pz, input int fz);
        for (int p = first; p < first + count; p++) begin
            @(negedge clk);
            bit_vld     = 1'b1;
            bit_in      = line_bit(p, pz, fz);
            fbit_strobe = (p == 0) || (p == F2);
        end
        @(negedge clk);
        bit_vld     = 1'b0;
        fbit_strobe = 1'b0;
        bit_in      = 1'b1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [4:0] d);
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd   = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [4:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [4:0] d;
        logic       prev;
        logic       exp;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        peek(2'd0, d);  check("R10 cfg after reset", d, 5'h00);
        peek(2'd1, d);  check("R10 status after reset", d, 5'h00);
        check("R10 irq after reset", irq, 1'b0);

        // R11 config readback and unused address
        reg_write(2'd0, 5'h15);
        peek(2'd0, d);  check("R11 cfg readback", d, 5'h15);
        reg_write(2'd0, 5'h1F);
        peek(2'd0, d);  check("R11 cfg readback all", d, 5'h1F);
        peek(2'd2, d);  check("R11 unused address", d, 5'h00);

        // table walk: R1 R2 R3 R5 R6 R9
        prev = 1'b0;
        for (int i = 0; i < 12; i++) begin
            exp = VECS[i][0];
            reg_write(2'd0, 5'h1C | {3'b000, VECS[i][6:5]});
            feed(0, WIN, int'(VECS[i][4:3]), int'(VECS[i][2:1]));
            check($sformatf("R9 irq vec%0d", i), irq, exp != prev);
            reg_read(2'd1, d);
            check($sformatf("R1 R2 R3 alarm vec%0d", i), d[0], exp);
            check($sformatf("R5 change vec%0d", i), d[1], exp != prev);
            peek(2'd1, d);
            check($sformatf("R6 cleared by read vec%0d", i), d[1], 1'b0);
            prev = exp;
        end

        // R6 with clear-on-read off, R7 write-one-to-clear
        reg_write(2'd0, 5'h0D);
        feed(0, WIN, 3, 0);
        reg_read(2'd1, d);  check("R6 read keeps flag", d, 5'h02);
        reg_read(2'd1, d);  check("R6 second read keeps flag", d, 5'h02);
        reg_write(2'd1, 5'h00);
        peek(2'd1, d);      check("R7 write zero no effect", d, 5'h02);
        reg_write(2'd1, 5'h02);
        peek(2'd1, d);      check("R7 write one clears", d, 5'h00);

        // R9 enable gating
        feed(0, WIN, 0, 0);
        peek(2'd1, d);      check("R5 flag set on rise", d, 5'h03);
        reg_write(2'd0, 5'h01); #1 check("R9 no enables", irq, 1'b0);
        reg_write(2'd0, 5'h05); #1 check("R9 source only", irq, 1'b0);
        reg_write(2'd0, 5'h09); #1 check("R9 block only", irq, 1'b0);
        reg_write(2'd0, 5'h0D); #1 check("R9 both enables", irq, 1'b1);
        reg_write(2'd1, 5'h02); #1 check("R9 drops on clear", irq, 1'b0);

        // R4 mid-window hold, R8 change beats clearing read
        reg_write(2'd0, 5'h1D);
        feed(0, WIN - 1, 3, 0);
        peek(2'd1, d);      check("R4 alarm held mid-window", d, 5'h01);
        @(negedge clk);
        bit_vld     = 1'b1;
        bit_in      = 1'b1;
        fbit_strobe = 1'b0;
        host_rd     = 1'b1;
        host_addr   = 2'd1;
        #1 check("R8 pre-edge status", host_rdata, 5'h01);
        @(negedge clk);
        bit_vld = 1'b0;
        host_rd = 1'b0;
        peek(2'd1, d);      check("R8 change survives read", d, 5'h02);
        check("R8 irq after collision", irq, 1'b1);

        // R1 disable while alarm present
        feed(0, WIN, 0, 0);
        peek(2'd1, d);      check("R2 alarm back", d[0], 1'b1);
        reg_read(2'd1, d);
        reg_write(2'd0, 5'h1C);
        peek(2'd1, d);      check("R1 disable forces clear", d, 5'h02);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule